// File: doc/BRIEF.md
# Control-Track Bit Pattern Shift Register

This block keeps an 8-bit long/short pattern for a tape control-track pulse stream. A separate measurement stage classifies each control pulse as long or short and strobes the result in on the pulse's rising edge. In playback or assemble mode, every strobe shifts the register left and the new classification enters at bit 0. In record mode, the register rotates on every strobe. Its top bit tells the pulse generator whether the next recorded pulse is long or short.

Pattern detection is a playback-only feature. It is active while the enable input is high and the index-detect disable input is low. Software arms a capture by pulsing the arm input. After eight more counted pulses the done flag sets and the arm clears itself. To start another capture, software clears the flag and then arms again. While detection is active the CPU cannot overwrite the register.

Top module: `ctl_pattern_reg`

## Requirements
- R1: Synchronous reset, or one clock with `hold_init_i` high, loads the register with 0xFF and clears the done flag, the arm state and the pulse counter.
- R2: With `mode_i` = 2'b00 (playback) or 2'b01 (assemble), each `pulse_stb_i` shifts the register left by one position. Bit 0 takes `long_i`, where 1 means long and 0 means short. This happens whatever the detection state is.
- R3: With `mode_i` = 2'b10 (record), each `pulse_stb_i` rotates the register left, so the old bit 7 lands in bit 0. `rec_long_o` always equals the present bit 7.
- R4: Detection is active when `mode_i` = 2'b00, `det_en_i` = 1 and `index_det_i` = 0. An `arm_wr_i` pulse during detection arms a capture and restarts the count at zero. On the eighth counted pulse, `done_o` sets and the arm clears.
- R5: Once set, `done_o` stays set through further pulses, which still shift the register, until `flag_clr_i` is asserted. A new capture needs a flag clear followed by a new arm.
- R6: If `flag_clr_i` falls in the same cycle as the pulse that completes a capture, the flag ends up set.
- R7: `cpu_wr_i` loads `cpu_data_i` into the register while detection is not active. It is ignored while detection is active.
- R8: A CPU write in the same cycle as a pulse strobe is dropped, and the shift or rotate is applied instead.
- R9: While `index_det_i` = 1, pulses still shift the register, but they are not counted and arm writes are ignored.
- R10: An `arm_wr_i` pulse while detection is not active has no effect, so a capture never completes from it.
- R11: With no strobe and no accepted write, the register holds its value. With `mode_i` = 2'b11 (off), strobes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_init_i | input | 1 | Standby / module-stop / control-stop reinitialise |
| mode_i | input | 2 | 00 playback, 01 assemble, 10 record, 11 off |
| pulse_stb_i | input | 1 | One-cycle strobe on control pulse rising edge |
| long_i | input | 1 | Classification of the strobed pulse, 1 = long |
| det_en_i | input | 1 | Pattern detection enable |
| arm_wr_i | input | 1 | Write of 1 to the arm bit |
| flag_clr_i | input | 1 | Write of 0 to the done flag |
| index_det_i | input | 1 | Index-signal detection active, disables pattern detection |
| cpu_wr_i | input | 1 | CPU write strobe for the register |
| cpu_data_i | input | 8 | CPU write data |
| pattern_o | output | 8 | Current register value |
| done_o | output | 1 | Eight-pulse capture done flag |
| rec_long_o | output | 1 | Record pulse length select, 1 = long |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the software flag clear and the hardware flag set. The bench arms a capture, sends seven pulses, and drives the flag clear in the same cycle as the eighth strobe. The flag must read set afterwards. The second pair is a CPU write and a pulse strobe. With detection off, the bench drives a CPU write together with a strobe and checks that the register holds the shifted value, not the written data.

// File: rtl/ctl_pattern_pkg.sv
package ctl_pattern_pkg;
  typedef enum logic [1:0] {
    MODE_PLAY = 2'b00,
    MODE_ASM  = 2'b01,
    MODE_REC  = 2'b10,
    MODE_OFF  = 2'b11
  } ctl_mode_e;
endpackage

// File: rtl/ctl_pattern_shreg.sv
module ctl_pattern_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_i,
  input  logic             shift_en_i,
  input  logic             rotate_en_i,
  input  logic             long_i,
  input  logic             load_en_i,
  input  logic [WIDTH-1:0] load_data_i,
  output logic [WIDTH-1:0] pattern_o
);
  localparam logic [WIDTH-1:0] INIT_VAL = '1;

  logic [WIDTH-1:0] pat_q;

  // priority: reinit, then pulse-driven update, then CPU load
  always_ff @(posedge clk) begin
    if (rst || init_i)    pat_q <= INIT_VAL;
    else if (shift_en_i)  pat_q <= {pat_q[WIDTH-2:0], long_i};
    else if (rotate_en_i) pat_q <= {pat_q[WIDTH-2:0], pat_q[WIDTH-1]};
    else if (load_en_i)   pat_q <= load_data_i;
  end

  assign pattern_o = pat_q;

  a_r1_init_ones: assert property (@(posedge clk)
    (rst || init_i) |=> (pat_q == INIT_VAL));
  a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
    (shift_en_i && !init_i) |=> (pat_q == {$past(pat_q[WIDTH-2:0]), $past(long_i)}));
  a_r3_rotate: assert property (@(posedge clk) disable iff (rst)
    (rotate_en_i && !shift_en_i && !init_i) |=> (pat_q[0] == $past(pat_q[WIDTH-1])));
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!init_i && !shift_en_i && !rotate_en_i && !load_en_i) |=> $stable(pat_q));
endmodule

// File: rtl/ctl_pattern_seq.sv
module ctl_pattern_seq #(
  parameter int PULSES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic init_i,
  input  logic det_active_i,
  input  logic pulse_i,
  input  logic arm_wr_i,
  input  logic flag_clr_i,
  output logic done_o
);
  localparam int CNT_W = (PULSES > 1) ? $clog2(PULSES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSES - 1);

  logic             arm_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             count_ev;
  logic             finish_ev;

  assign count_ev  = det_active_i && arm_q && !done_q && pulse_i && !arm_wr_i;
  assign finish_ev = count_ev && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      arm_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (arm_wr_i && det_active_i) begin
        arm_q <= 1'b1;
        cnt_q <= '0;
      end else if (finish_ev) begin
        arm_q <= 1'b0;
        cnt_q <= '0;
      end else if (count_ev) begin
        cnt_q <= cnt_q + 1'b1;
      end
      // a completing pulse wins over a flag clear in the same cycle
      if (finish_ev)       done_q <= 1'b1;
      else if (flag_clr_i) done_q <= 1'b0;
    end
  end

  assign done_o = done_q;

  a_r4_arm_drops: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> !arm_q);
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done_q && !flag_clr_i && !init_i) |=> done_q);
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (det_active_i && arm_q && !done_q && pulse_i && !arm_wr_i && cnt_q == LAST && !init_i) |=> done_q);
  a_r9_no_count_idle: assert property (@(posedge clk) disable iff (rst)
    (!det_active_i && !init_i) |=> $stable(cnt_q));
  a_r10_arm_gate: assert property (@(posedge clk) disable iff (rst)
    (!det_active_i && !arm_q) |=> !arm_q);
endmodule

// File: rtl/ctl_pattern_reg.sv
module ctl_pattern_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_init_i,
  input  logic [1:0]       mode_i,
  input  logic             pulse_stb_i,
  input  logic             long_i,
  input  logic             det_en_i,
  input  logic             arm_wr_i,
  input  logic             flag_clr_i,
  input  logic             index_det_i,
  input  logic             cpu_wr_i,
  input  logic [WIDTH-1:0] cpu_data_i,
  output logic [WIDTH-1:0] pattern_o,
  output logic             done_o,
  output logic             rec_long_o
);
  import ctl_pattern_pkg::*;

  ctl_mode_e mode;
  logic      det_active;
  logic      shift_en;
  logic      rotate_en;
  logic      load_en;

  assign mode       = ctl_mode_e'(mode_i);
  assign det_active = (mode == MODE_PLAY) && det_en_i && !index_det_i;
  assign shift_en   = pulse_stb_i && ((mode == MODE_PLAY) || (mode == MODE_ASM));
  assign rotate_en  = pulse_stb_i && (mode == MODE_REC);
  assign load_en    = cpu_wr_i && !det_active;

  ctl_pattern_shreg #(.WIDTH(WIDTH)) u_shreg (
    .clk         (clk),
    .rst         (rst),
    .init_i      (hold_init_i),
    .shift_en_i  (shift_en),
    .rotate_en_i (rotate_en),
    .long_i      (long_i),
    .load_en_i   (load_en),
    .load_data_i (cpu_data_i),
    .pattern_o   (pattern_o)
  );

  ctl_pattern_seq #(.PULSES(WIDTH)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .init_i       (hold_init_i),
    .det_active_i (det_active),
    .pulse_i      (pulse_stb_i),
    .arm_wr_i     (arm_wr_i),
    .flag_clr_i   (flag_clr_i),
    .done_o       (done_o)
  );

  assign rec_long_o = pattern_o[WIDTH-1];

  a_r7_write_blocked: assert property (@(posedge clk) disable iff (rst)
    (det_active && cpu_wr_i && !pulse_stb_i && !hold_init_i) |=> $stable(pattern_o));
  a_r11_off_mode: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF && !cpu_wr_i && !hold_init_i) |=> $stable(pattern_o));
endmodule

// File: tb/ctl_pattern_reg_tb.sv
module ctl_pattern_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, hold_init, pulse_stb, long_b, det_en, arm_wr, flag_clr, index_det, cpu_wr;
  logic [1:0]   mode;
  logic [W-1:0] cpu_data;
  logic [W-1:0] pattern;
  logic done, rec_long;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_pattern_reg #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .hold_init_i(hold_init), .mode_i(mode),
    .pulse_stb_i(pulse_stb), .long_i(long_b), .det_en_i(det_en),
    .arm_wr_i(arm_wr), .flag_clr_i(flag_clr), .index_det_i(index_det),
    .cpu_wr_i(cpu_wr), .cpu_data_i(cpu_data),
    .pattern_o(pattern), .done_o(done), .rec_long_o(rec_long)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, launched at a falling edge, observed at the next one
  task automatic cyc(input logic stb, input logic lng, input logic arm,
                     input logic clr, input logic wr, input logic [W-1:0] d);
    pulse_stb = stb; long_b = lng; arm_wr = arm; flag_clr = clr; cpu_wr = wr; cpu_data = d;
    @(negedge clk);
    pulse_stb = 0; arm_wr = 0; flag_clr = 0; cpu_wr = 0;
  endtask

  task automatic pulses(input int n, input logic lng);
    for (int i = 0; i < n; i++) cyc(1, lng, 0, 0, 0, '0);
  endtask

  task automatic t_reset;
    check("R1 reset pattern", pattern, 8'hFF);
    check("R1 reset done", {7'b0, done}, 8'h00);
    check("R3 rec_long after reset", {7'b0, rec_long}, 8'h01);
  endtask

  task automatic t_play_shift;
    mode = 2'b00; det_en = 0;
    cyc(1,1,0,0,0,0); cyc(1,0,0,0,0,0); cyc(1,1,0,0,0,0); cyc(1,1,0,0,0,0);
    cyc(1,0,0,0,0,0); cyc(1,0,0,0,0,0); cyc(1,1,0,0,0,0); cyc(1,0,0,0,0,0);
    check("R2 playback shift", pattern, 8'hB2);
    mode = 2'b01;
    cyc(1,1,0,0,0,0);
    check("R2 assemble shift", pattern, 8'h65);
  endtask

  task automatic t_cpu_write;
    mode = 2'b00; det_en = 0;
    cyc(0,0,0,0,1,8'h5A);
    check("R7 write accepted", pattern, 8'h5A);
    det_en = 1;
    cyc(0,0,0,0,1,8'h33);
    check("R7 write ignored", pattern, 8'h5A);
    det_en = 0;
  endtask

  task automatic t_record;
    mode = 2'b10;
    cyc(0,0,0,0,1,8'h81);
    check("R3 rec_long bit7 set", {7'b0, rec_long}, 8'h01);
    cyc(1,0,0,0,0,0);
    check("R3 rotate 1", pattern, 8'h03);
    check("R3 rec_long bit7 clear", {7'b0, rec_long}, 8'h00);
    cyc(1,1,0,0,0,0);
    check("R3 rotate 2", pattern, 8'h06);
    cyc(0,0,0,0,0,0); cyc(0,0,0,0,0,0);
    check("R11 hold idle", pattern, 8'h06);
    mode = 2'b11;
    pulses(3, 1);
    check("R11 off mode", pattern, 8'h06);
  endtask

  task automatic t_capture;
    mode = 2'b00; det_en = 0;
    cyc(0,0,0,0,1,8'h00);
    det_en = 1;
    cyc(0,0,1,0,0,0);
    pulses(7, 1);
    check("R4 not done after 7", {7'b0, done}, 8'h00);
    pulses(1, 1);
    check("R4 done after 8", {7'b0, done}, 8'h01);
    check("R4 pattern", pattern, 8'hFF);
    pulses(2, 0);
    check("R5 still done", {7'b0, done}, 8'h01);
    check("R5 shifts while done", pattern, 8'hFC);
    cyc(0,0,0,1,0,0);
    check("R5 cleared", {7'b0, done}, 8'h00);
    cyc(0,0,1,0,0,0);
    pulses(8, 0);
    check("R5 recapture", {7'b0, done}, 8'h01);
  endtask

  task automatic t_collide;
    mode = 2'b00; det_en = 1;
    cyc(0,0,0,1,0,0);
    cyc(0,0,1,0,0,0);
    pulses(7, 1);
    cyc(1,1,0,1,0,0);
    check("R6 set wins over clear", {7'b0, done}, 8'h01);
    cyc(0,0,0,1,0,0);
    det_en = 0;
    cyc(1,0,0,0,1,8'h0F);
    check("R8 shift beats write", pattern, 8'hFE);
  endtask

  task automatic t_index;
    mode = 2'b00; det_en = 1; index_det = 1;
    cyc(0,0,1,0,0,0);
    pulses(8, 1);
    check("R9 shifts during index", pattern, 8'hFF);
    check("R9 no count during index", {7'b0, done}, 8'h00);
    index_det = 0;
    pulses(8, 0);
    check("R9 arm ignored during index", {7'b0, done}, 8'h00);
    det_en = 0;
    cyc(0,0,1,0,0,0);
    det_en = 1;
    pulses(8, 1);
    check("R10 arm ignored when inactive", {7'b0, done}, 8'h00);
  endtask

  task automatic t_hold_init;
    mode = 2'b00; det_en = 1;
    cyc(0,0,1,0,0,0);
    pulses(8, 0);
    check("R1 done before init", {7'b0, done}, 8'h01);
    hold_init = 1;
    @(negedge clk);
    hold_init = 0;
    check("R1 init pattern", pattern, 8'hFF);
    check("R1 init done", {7'b0, done}, 8'h00);
  endtask

  initial begin
    rst = 1; hold_init = 0; mode = 2'b11; pulse_stb = 0; long_b = 0; det_en = 0;
    arm_wr = 0; flag_clr = 0; index_det = 0; cpu_wr = 0; cpu_data = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_play_shift();
    t_cpu_write();
    t_record();
    t_capture();
    t_collide();
    t_index();
    t_hold_init();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule